// File: doc/BRIEF.md
# Per-Pipeline Semaphore Wait Unit

This block holds a pool of hardware semaphores that lets one producer core hand work to two consumer subblocks, and lets those subblocks report back. A single set port names a semaphore and adds one to its count. Each execution pipeline on the core, such as vector, load DMA and store DMA, has its own wait port. A pipeline uses that port to name the semaphore it needs. If the count is non-zero the wait finishes at once. If the count is zero only that pipeline is stalled, and the other pipelines keep running.

The 32-entry ID space is split between the two subblocks. ID bit 4 picks the subblock and bits 3:0 pick one of that subblock's 16 physical counters. A set reaches exactly one counter, so signalling both subblocks takes two sets, one to n and one to n+16. The ID ports are wider than five bits so that out-of-range IDs can be presented and flagged. A wait on a semaphore that has never been set is refused and flagged, and so is a set that would overflow a counter.

Top module: `pipe_sem_wait`

## Requirements
- R1: After reset every stall, wake and error output is 0, every counter is 0, and no semaphore is marked as ever set.
- R2: A legal wait on a semaphore whose count is non-zero raises that pipeline's wake in the same cycle, does not stall, and lowers the count by one.
- R3: A legal wait on a semaphore whose count is zero raises that pipeline's stall from that cycle on. The stall holds until a set to the same ID arrives. In that set's cycle wake rises, stall falls and the count stays 0.
- R4: A stall affects only the pipeline that issued the wait. While a pipeline is stalled, its wait_vld and wait_id are ignored.
- R5: ID bit 4 selects the subblock and bits 3:0 select the counter within it. IDs n and n+16 are separate semaphores, and one set never reaches both.
- R6: A set or wait with an ID of 32 or more raises err_id one cycle later and has no other effect.
- R7: A wait on a semaphore that has never been set raises err_unset one cycle later and is dropped without stalling. A set to the same ID in the same cycle counts as having set it.
- R8: Counters saturate at 15. A set at count 15 with no wait consuming that semaphore in the same cycle raises err_ovf one cycle later and leaves the count at 15. If a wait does consume it in that cycle, no error is raised.
- R9: Each semaphore grants at most one wait per cycle. When several pipelines compete for it, the lowest-numbered pipeline wins and the others stall.
- R10: Pipelines blocked on different semaphores are released independently, and several may be released in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_vld | input | 1 | Set request this cycle |
| set_id | input | 6 | Semaphore ID for the set |
| wait_vld | input | 3 | Wait request, one bit per pipeline |
| wait_id | input | 18 | Wait IDs, pipeline p at bits p*6+5:p*6 |
| stall | output | 3 | Pipeline p is blocked this cycle |
| wake | output | 3 | Pipeline p's wait completes this cycle |
| err_id | output | 1 | An out-of-range ID was seen last cycle |
| err_unset | output | 1 | A wait targeted a never-set semaphore last cycle |
| err_ovf | output | 1 | A set hit a saturated counter last cycle |

## Verification
The bench goes after the cases a weak design gets wrong. One is a set and a wait meeting a zero counter in the same cycle; a design that gets it wrong leaves the pipeline stalled or lets the count rise to 1. Another is three pipelines racing for a single count, where a wrong priority wakes pipeline 2 first or wakes more than one. It also drives a wait into a pipeline that is already stalled, which a careless design would use to retarget the pending wait. It checks the pair n and n+16, where a design that decodes too few bits would make a single set release both subblocks, and the top of the counter, where a design without saturation wraps to 0 and loses fifteen credits.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PSW_CNT_W = 4;
  localparam int PSW_SUB_W = 4;

  function automatic logic [PSW_CNT_W-1:0] cnt_max();
    return {PSW_CNT_W{1'b1}};
  endfunction
endpackage

// File: rtl/psw_sem_bank.sv
module psw_sem_bank
  import psw_pkg::*;
#(
  parameter int NS   = 32,
  parameter int CW   = PSW_CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] inc,
  input  logic [NS-1:0] dec,
  output logic [NS-1:0] cnt_nz,
  output logic [NS-1:0] ever,
  output logic          ovf
);
  localparam logic [CW-1:0] MAXC = {CW{1'b1}};

  logic [NS-1:0] ovf_vec;

  for (genvar s = 0; s < NS; s++) begin : g_sem
    logic [CW-1:0] cnt_q, cnt_d;
    logic          ever_q, ever_d;
    logic          cnt_en;

    always_comb begin
      cnt_d      = cnt_q;
      ovf_vec[s] = 1'b0;
      unique case ({inc[s], dec[s]})
        2'b10: begin
          if (cnt_q == MAXC) ovf_vec[s] = 1'b1;
          else               cnt_d = cnt_q + 1'b1;
        end
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
      cnt_en = inc[s] ^ dec[s];
      ever_d = ever_q | inc[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q  <= '0;
        ever_q <= 1'b0;
      end else begin
        if (cnt_en) cnt_q  <= cnt_d;
        if (inc[s]) ever_q <= ever_d;
      end
    end

    assign cnt_nz[s] = (cnt_q != '0);
    assign ever[s]   = ever_q;

    // R3: a grant never takes a count that is not there
    a_r3_dec_guard: assert property (@(posedge clk) disable iff (!rst_n)
      dec[s] |-> (cnt_q != '0 || inc[s]));
    // R7: a grant only goes to a semaphore that has been set
    a_r7_dec_set: assert property (@(posedge clk) disable iff (!rst_n)
      dec[s] |-> (ever_q || inc[s]));
    // R8: saturation holds the ceiling
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == MAXC && inc[s] && !dec[s]) |=> cnt_q == MAXC);
  end

  assign ovf = |ovf_vec;
endmodule

// File: rtl/psw_wait_arb.sv
module psw_wait_arb #(
  parameter int NP    = 3,
  parameter int ID_W  = 6,
  parameter int IDX_W = 5,
  parameter int NS    = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    wait_vld,
  input  logic [NP*ID_W-1:0] wait_id,
  input  logic [NS-1:0]    set_hit,
  input  logic [NS-1:0]    cnt_nz,
  input  logic [NS-1:0]    ever,
  output logic [NP-1:0]    grant,
  output logic [NP-1:0]    stall,
  output logic [NS-1:0]    dec,
  output logic             bad_wait,
  output logic             unset_wait
);
  logic [NP-1:0]    pend_q;
  logic [IDX_W-1:0] psem_q [NP];
  logic [IDX_W-1:0] sem_sel [NP];
  logic [NP-1:0]    load;
  logic [NP-1:0]    act;
  logic [NS-1:0]    taken;
  logic [ID_W-1:0]  nid;
  logic [IDX_W-1:0] nidx;

  always_comb begin
    taken      = '0;
    grant      = '0;
    stall      = '0;
    act        = '0;
    load       = '0;
    bad_wait   = 1'b0;
    unset_wait = 1'b0;
    nid        = '0;
    nidx       = '0;
    for (int p = 0; p < NP; p++) begin
      sem_sel[p] = psem_q[p];
      nid        = wait_id[p*ID_W +: ID_W];
      nidx       = nid[IDX_W-1:0];
      if (pend_q[p]) begin
        act[p] = 1'b1;
      end else if (wait_vld[p]) begin
        if ((nid >> IDX_W) != '0) begin
          bad_wait = 1'b1;
        end else if (!(ever[nidx] || set_hit[nidx])) begin
          unset_wait = 1'b1;
        end else begin
          act[p]     = 1'b1;
          load[p]    = 1'b1;
          sem_sel[p] = nidx;
        end
      end
      if (act[p]) begin
        if ((cnt_nz[sem_sel[p]] || set_hit[sem_sel[p]]) && !taken[sem_sel[p]]) begin
          grant[p]            = 1'b1;
          taken[sem_sel[p]]   = 1'b1;
        end else begin
          stall[p] = 1'b1;
        end
      end
    end
  end

  assign dec = taken;

  for (genvar p = 0; p < NP; p++) begin : g_pipe
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[p] <= 1'b0;
        psem_q[p] <= '0;
      end else begin
        pend_q[p] <= stall[p];
        if (load[p]) psem_q[p] <= sem_sel[p];
      end
    end

    // R4: a held wait keeps its target until released
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[p] && !grant[p]) |=> (pend_q[p] && $stable(psem_q[p])));
    // R3: stall and wake never coincide on one pipeline
    a_r3_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(stall[p] && grant[p]));
  end
endmodule

// File: rtl/pipe_sem_wait.sv
module pipe_sem_wait
  import psw_pkg::*;
#(
  parameter int NP   = 3,
  parameter int ID_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_vld,
  input  logic [ID_W-1:0]   set_id,
  input  logic [NP-1:0]     wait_vld,
  input  logic [NP*ID_W-1:0] wait_id,
  output logic [NP-1:0]     stall,
  output logic [NP-1:0]     wake,
  output logic              err_id,
  output logic              err_unset,
  output logic              err_ovf
);
  localparam int IDX_W = PSW_SUB_W + 1;
  localparam int NS    = 1 << IDX_W;

  logic [NS-1:0] set_hit, cnt_nz, ever, dec;
  logic          set_bad, wait_bad, wait_unset, ovf;
  logic          err_id_d, err_unset_d, err_ovf_d;

  always_comb begin
    set_hit = '0;
    set_bad = 1'b0;
    if (set_vld) begin
      if ((set_id >> IDX_W) != '0) set_bad = 1'b1;
      else                         set_hit[set_id[IDX_W-1:0]] = 1'b1;
    end
  end

  psw_sem_bank #(.NS(NS), .CW(PSW_CNT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .inc(set_hit), .dec(dec),
    .cnt_nz(cnt_nz), .ever(ever), .ovf(ovf)
  );

  psw_wait_arb #(.NP(NP), .ID_W(ID_W), .IDX_W(IDX_W), .NS(NS)) u_arb (
    .clk(clk), .rst_n(rst_n), .wait_vld(wait_vld), .wait_id(wait_id),
    .set_hit(set_hit), .cnt_nz(cnt_nz), .ever(ever),
    .grant(wake), .stall(stall), .dec(dec),
    .bad_wait(wait_bad), .unset_wait(wait_unset)
  );

  always_comb begin
    err_id_d    = set_bad | wait_bad;
    err_unset_d = wait_unset;
    err_ovf_d   = ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_id    <= 1'b0;
      err_unset <= 1'b0;
      err_ovf   <= 1'b0;
    end else begin
      err_id    <= err_id_d;
      err_unset <= err_unset_d;
      err_ovf   <= err_ovf_d;
    end
  end

  // R5: a set reaches at most one semaphore
  a_r5_no_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dec & set_hit) && $countones(set_hit) <= 1);
  // R6: an out-of-range set is flagged next cycle
  a_r6_bad_set: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vld && set_hit == '0) |=> err_id);
endmodule

// File: tb/pipe_sem_wait_test.sv
module pipe_sem_wait_test;
  localparam int NP = 3;
  localparam int IW = 6;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            set_vld;
  logic [IW-1:0]   set_id;
  logic [NP-1:0]   wait_vld;
  logic [NP*IW-1:0] wait_id;
  logic [NP-1:0]   stall, wake;
  logic            err_id, err_unset, err_ovf;

  pipe_sem_wait uut (
    .clk(clk), .rst_n(rst_n), .set_vld(set_vld), .set_id(set_id),
    .wait_vld(wait_vld), .wait_id(wait_id), .stall(stall), .wake(wake),
    .err_id(err_id), .err_unset(err_unset), .err_ovf(err_ovf)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int  m_cnt [32];
  bit  m_ever [32];
  bit  m_pend [NP];
  int  m_psem [NP];
  bit  e_id, e_unset, e_ovf;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit sv, input int sid, input bit [NP-1:0] wv,
                      input int i0, input int i1, input int i2, input string tag);
    int ids [NP];
    bit [NP-1:0] x_wake, x_stall;
    bit taken [32];
    bit n_id, n_unset, n_ovf, sleg;
    int sem;
    bit actv;
    ids[0] = i0; ids[1] = i1; ids[2] = i2;
    @(negedge clk);
    set_vld  = sv;
    set_id   = sid[IW-1:0];
    wait_vld = wv;
    for (int p = 0; p < NP; p++) wait_id[p*IW +: IW] = ids[p][IW-1:0];
    #2;
    x_wake = '0; x_stall = '0; n_id = 0; n_unset = 0; n_ovf = 0;
    for (int s = 0; s < 32; s++) taken[s] = 0;
    sleg = sv && sid < 32;
    if (sv && !sleg) n_id = 1;
    for (int p = 0; p < NP; p++) begin
      actv = 0; sem = 0;
      if (m_pend[p]) begin
        actv = 1; sem = m_psem[p];
      end else if (wv[p]) begin
        if (ids[p] >= 32) n_id = 1;
        else if (!(m_ever[ids[p]] || (sleg && sid == ids[p]))) n_unset = 1;
        else begin actv = 1; sem = ids[p]; end
      end
      if (actv) begin
        if ((m_cnt[sem] > 0 || (sleg && sid == sem)) && !taken[sem]) begin
          x_wake[p] = 1; taken[sem] = 1;
        end else x_stall[p] = 1;
        m_psem[p] = sem;
      end
      m_pend[p] = x_stall[p];
    end
    check(wake == x_wake, tag, "wake", int'(wake), int'(x_wake));
    check(stall == x_stall, tag, "stall", int'(stall), int'(x_stall));
    check(err_id == e_id, tag, "err_id", int'(err_id), int'(e_id));
    check(err_unset == e_unset, tag, "err_unset", int'(err_unset), int'(e_unset));
    check(err_ovf == e_ovf, tag, "err_ovf", int'(err_ovf), int'(e_ovf));
    for (int s = 0; s < 32; s++) begin
      if (sleg && sid == s) begin
        m_ever[s] = 1;
        if (taken[s]) ;
        else if (m_cnt[s] == 15) n_ovf = 1;
        else m_cnt[s]++;
      end else if (taken[s]) m_cnt[s]--;
    end
    e_id = n_id; e_unset = n_unset; e_ovf = n_ovf;
  endtask

  task automatic idle(input string tag);
    step(0, 0, 3'b000, 0, 0, 0, tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 32; s++) begin m_cnt[s] = 0; m_ever[s] = 0; end
    for (int p = 0; p < NP; p++) begin m_pend[p] = 0; m_psem[p] = 0; end
    e_id = 0; e_unset = 0; e_ovf = 0;
    rst_n = 1'b0; set_vld = 0; set_id = '0; wait_vld = '0; wait_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, nothing marked as set
    idle("R1");
    step(0, 0, 3'b001, 3, 0, 0, "R1");
    idle("R1");
    // R2: count available, immediate wake
    step(1, 3, 3'b000, 0, 0, 0, "R2");
    step(0, 0, 3'b001, 3, 0, 0, "R2");
    // R3: zero count stalls until set
    step(0, 0, 3'b001, 3, 0, 0, "R3");
    idle("R3");
    // R4: other pipe proceeds, stalled pipe ignores new request
    step(1, 19, 3'b000, 0, 0, 0, "R4");
    step(1, 19, 3'b010, 0, 19, 0, "R4");
    step(0, 0, 3'b001, 19, 0, 0, "R4");
    step(0, 0, 3'b010, 0, 19, 0, "R4");
    step(1, 3, 3'b000, 0, 0, 0, "R3");
    idle("R3");
    // R5: n and n+16 are separate
    step(1, 5, 3'b000, 0, 0, 0, "R5");
    step(0, 0, 3'b100, 0, 0, 21, "R5");
    idle("R5");
    step(1, 21, 3'b000, 0, 0, 0, "R5");
    step(0, 0, 3'b101, 5, 0, 21, "R5");
    step(0, 0, 3'b001, 5, 0, 0, "R5");
    step(1, 21, 3'b000, 0, 0, 0, "R5");
    // R6: out-of-range IDs
    step(1, 40, 3'b000, 0, 0, 0, "R6");
    step(0, 0, 3'b010, 0, 33, 0, "R6");
    idle("R6");
    // R7: set in same cycle makes wait legal; otherwise flagged
    step(1, 7, 3'b010, 0, 7, 0, "R7");
    step(0, 0, 3'b100, 0, 0, 8, "R7");
    idle("R7");
    // R8: saturation and overflow
    for (int k = 0; k < 16; k++) step(1, 9, 3'b000, 0, 0, 0, "R8");
    idle("R8");
    step(1, 9, 3'b001, 9, 0, 0, "R8");
    idle("R8");
    for (int k = 0; k < 15; k++) step(0, 0, 3'b010, 0, 9, 0, "R8");
    step(0, 0, 3'b010, 0, 9, 0, "R8");
    step(1, 9, 3'b000, 0, 0, 0, "R8");
    idle("R8");
    // R9: priority on one count
    step(1, 10, 3'b000, 0, 0, 0, "R9");
    step(0, 0, 3'b111, 10, 10, 10, "R9");
    idle("R9");
    step(1, 10, 3'b000, 0, 0, 0, "R9");
    step(1, 10, 3'b000, 0, 0, 0, "R9");
    idle("R9");
    // R10: independent release on different semaphores
    step(1, 11, 3'b000, 0, 0, 0, "R10");
    step(1, 12, 3'b011, 11, 0, 0, "R10");
    step(0, 0, 3'b011, 11, 12, 0, "R10");
    step(1, 12, 3'b000, 0, 0, 0, "R10");
    idle("R10");
    step(1, 11, 3'b000, 0, 0, 0, "R10");
    step(1, 13, 3'b000, 0, 0, 0, "R10");
    step(1, 14, 3'b011, 13, 14, 0, "R10");
    idle("R10");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule